// File: doc/BRIEF.md
# Peripheral-to-Memory Single-Byte DMA Mover

This block moves one byte from a peripheral's data register into a memory location each time the peripheral asks for service. The processor does not take an interrupt. Before any move, the processor loads a source address and a destination address through a small configuration port. A move is refused until both addresses have been written at least once since reset.

When the peripheral raises its request, the block asks the processor for the system bus with a hold request and waits for the hold grant. After the grant it acknowledges the peripheral. It then runs one seven-phase bus transaction. The I/O read strobe fetches the byte from the source address. The memory write strobe stores that byte at the destination address. The two strobes overlap for two phases. At the end of the transaction the block drops the hold request and the peripheral acknowledge together. It does not ask for the bus again until the peripheral has withdrawn its request and the processor has withdrawn its grant.

A completed-move counter can be read back through the configuration port. The bus outputs carry an explicit output enable, meant to control the chip-level tri-state drivers. That enable is active only while the grant is held.

Top module: `dma_p2m_ctrl`

## Requirements
- R1: While reset is asserted, and until the first transaction, `hold_req`, `per_ack`, `bus_oe`, every strobe, both address outputs and `bus_wdata` are 0. The source, destination and move-count registers read back as 0.
- R2: Register select codes on `cfg_sel` are: 0 for source address, 1 for destination address, 2 for move count, and 3 reads as 0. When `cfg_we` is high at a clock edge, `cfg_wdata` is stored into the selected address register. `cfg_rdata` shows the selected register in the same cycle.
- R3: `per_req` is ignored, and `hold_req` stays 0, until both the source and the destination register have been written since reset.
- R4: When the block is idle and armed, and `per_req` is sampled high, `hold_req` rises one cycle later. It stays high through the whole transaction.
- R5: `per_ack` and the transaction start one cycle after `hold_ack` is sampled high while `hold_req` is high. `per_ack` is never high without `hold_req`.
- R6: `bus_oe` is high only during a transaction, and only in cycles where `hold_ack` is high. Whenever `bus_oe` is 0, all strobes, both address outputs and `bus_wdata` are 0.
- R7: A transaction lasts 7 cycles, numbered phase 0 to 6. `bus_ale` is high in phase 0. `bus_io_rd` is high in phases 1 to 4. `bus_mem_wr` is high in phases 3 to 5, so the two strobes overlap in phases 3 and 4. Phase 6 has no strobe.
- R8: During a transaction, `bus_io_addr` carries the source register and `bus_mem_addr` carries the destination register. The byte on `bus_rdata` at the phase-2 clock edge is driven on `bus_wdata` while `bus_mem_wr` is high. If the grant is absent at that edge, the previously captured byte is kept.
- R9: In the cycle after phase 6, `hold_req` and `per_ack` fall together. The move count rises by one and wraps modulo 256.
- R10: After a transaction, `hold_req` stays 0 until `per_req` and `hold_ack` have both been sampled low. A new request is accepted only after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select: 0 source, 1 destination, 2 count |
| cfg_wdata | input | 16 | Configuration write data |
| cfg_rdata | output | 16 | Selected register readback |
| per_req | input | 1 | Peripheral service request |
| per_ack | output | 1 | Acknowledge to the peripheral |
| hold_req | output | 1 | Request for the system bus to the processor |
| hold_ack | input | 1 | Processor has released the bus |
| bus_oe | output | 1 | Output enable for the bus drivers |
| bus_ale | output | 1 | Address latch strobe, phase 0 |
| bus_io_rd | output | 1 | I/O read strobe |
| bus_mem_wr | output | 1 | Memory write strobe |
| bus_io_addr | output | 16 | Source (peripheral) address |
| bus_mem_addr | output | 16 | Destination (memory) address |
| bus_rdata | input | 8 | Data returned by the peripheral |
| bus_wdata | output | 8 | Data written to memory |

## Verification
The results arrive at fixed delays after the input that causes them:
- `hold_req` changes one edge after `per_req` is sampled.
- `per_ack`, `bus_oe` and `bus_ale` follow one edge after `hold_ack` is sampled. The strobes then advance one phase per edge.
- The byte sampled at the phase-2 edge appears on `bus_wdata` from phase 3.
- The move count is visible on readback one edge after phase 6.
- Releasing reset adds two synchronizer edges before the first state change.

The bench changes inputs 2 ns after each rising edge. A reference model advances on the same edges as the design, and every output is compared with it at the falling edge. The reference model and these explicit checks are therefore always evaluated in the cycle in which each result is due.

// File: rtl/dma_p2m_pkg.sv
package dma_p2m_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_HOLD  = 2'd1,
    ST_MOVE  = 2'd2,
    ST_DRAIN = 2'd3
  } seq_state_t;

  localparam logic [1:0] SEL_SRC = 2'd0;
  localparam logic [1:0] SEL_DST = 2'd1;
  localparam logic [1:0] SEL_CNT = 2'd2;

endpackage

// File: rtl/dma_rst_sync.sv
module dma_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic s0_q, s1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s0_q <= 1'b0;
      s1_q <= 1'b0;
    end else begin
      s0_q <= 1'b1;
      s1_q <= s0_q;
    end
  end

  assign rst_n_sync = s1_q;
endmodule

// File: rtl/dma_cfg_regs.sv
module dma_cfg_regs
  import dma_p2m_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  input  logic          cnt_inc,
  output logic [AW-1:0] cfg_rdata,
  output logic [AW-1:0] src_addr,
  output logic [AW-1:0] dst_addr,
  output logic          armed
);
  logic [AW-1:0] src_q, dst_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          src_set_q, dst_set_q;
  logic          src_en, dst_en;

  // Clock enables and next values
  always_comb begin
    src_en = cfg_we && (cfg_sel == SEL_SRC);
    dst_en = cfg_we && (cfg_sel == SEL_DST);
    cnt_d  = cnt_q + {{(CW-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q     <= '0;
      dst_q     <= '0;
      cnt_q     <= '0;
      src_set_q <= 1'b0;
      dst_set_q <= 1'b0;
    end else begin
      if (src_en) begin
        src_q     <= cfg_wdata;
        src_set_q <= 1'b1;
      end
      if (dst_en) begin
        dst_q     <= cfg_wdata;
        dst_set_q <= 1'b1;
      end
      if (cnt_inc) cnt_q <= cnt_d;
    end
  end

  // Readback mux
  always_comb begin
    unique case (cfg_sel)
      SEL_SRC: cfg_rdata = src_q;
      SEL_DST: cfg_rdata = dst_q;
      SEL_CNT: cfg_rdata = AW'(cnt_q);
      default: cfg_rdata = '0;
    endcase
  end

  assign src_addr = src_q;
  assign dst_addr = dst_q;
  assign armed    = src_set_q && dst_set_q;
endmodule

// File: rtl/dma_seq_fsm.sv
module dma_seq_fsm
  import dma_p2m_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic armed,
  input  logic per_req,
  input  logic hold_ack,
  input  logic move_done,
  output logic hold_req,
  output logic per_ack,
  output logic move_active,
  output logic cnt_inc
);
  seq_state_t st_q, st_d;

  // Next-state logic
  always_comb begin
    st_d    = st_q;
    cnt_inc = 1'b0;
    unique case (st_q)
      ST_IDLE:  if (armed && per_req) st_d = ST_HOLD;
      ST_HOLD:  if (hold_ack) st_d = ST_MOVE;
      ST_MOVE:  if (move_done) begin
                  st_d    = ST_DRAIN;
                  cnt_inc = 1'b1;
                end
      ST_DRAIN: if (!per_req && !hold_ack) st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign hold_req    = (st_q == ST_HOLD) || (st_q == ST_MOVE);
  assign per_ack     = (st_q == ST_MOVE);
  assign move_active = (st_q == ST_MOVE);
endmodule

// File: rtl/dma_bus_phase.sv
module dma_bus_phase #(
  parameter int AW     = 16,
  parameter int DW     = 8,
  parameter int PHASES = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          move_active,
  input  logic          hold_ack,
  input  logic [AW-1:0] src_addr,
  input  logic [AW-1:0] dst_addr,
  input  logic [DW-1:0] bus_rdata,
  output logic          move_done,
  output logic          bus_oe,
  output logic          bus_ale,
  output logic          bus_io_rd,
  output logic          bus_mem_wr,
  output logic [AW-1:0] bus_io_addr,
  output logic [AW-1:0] bus_mem_addr,
  output logic [DW-1:0] bus_wdata
);
  localparam int PW = $clog2(PHASES);
  localparam logic [PW-1:0] PH_ALE    = PW'(0);
  localparam logic [PW-1:0] PH_RD_BEG = PW'(1);
  localparam logic [PW-1:0] PH_SAMPLE = PW'(2);
  localparam logic [PW-1:0] PH_WR_BEG = PW'(3);
  localparam logic [PW-1:0] PH_RD_END = PW'(4);
  localparam logic [PW-1:0] PH_WR_END = PW'(PHASES-2);
  localparam logic [PW-1:0] PH_LAST   = PW'(PHASES-1);

  logic [PW-1:0] phase_q, phase_d;
  logic [DW-1:0] lat_q;
  logic          lat_en;

  // Phase sequencing and capture enable
  always_comb begin
    if (!move_active || (phase_q == PH_LAST)) phase_d = '0;
    else                                      phase_d = phase_q + PW'(1);
    lat_en = bus_oe && (phase_q == PH_SAMPLE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      lat_q   <= '0;
    end else begin
      phase_q <= phase_d;
      if (lat_en) lat_q <= bus_rdata;
    end
  end

  // Bus drive, gated by the grant
  always_comb begin
    bus_oe       = move_active && hold_ack;
    bus_ale      = bus_oe && (phase_q == PH_ALE);
    bus_io_rd    = bus_oe && (phase_q >= PH_RD_BEG) && (phase_q <= PH_RD_END);
    bus_mem_wr   = bus_oe && (phase_q >= PH_WR_BEG) && (phase_q <= PH_WR_END);
    bus_io_addr  = bus_oe ? src_addr : '0;
    bus_mem_addr = bus_oe ? dst_addr : '0;
    bus_wdata    = bus_mem_wr ? lat_q : '0;
  end

  assign move_done = move_active && (phase_q == PH_LAST);
endmodule

// File: rtl/dma_p2m_ctrl.sv
module dma_p2m_ctrl #(
  parameter int AW     = 16,
  parameter int DW     = 8,
  parameter int CW     = 8,
  parameter int PHASES = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  output logic [AW-1:0] cfg_rdata,
  input  logic          per_req,
  output logic          per_ack,
  output logic          hold_req,
  input  logic          hold_ack,
  output logic          bus_oe,
  output logic          bus_ale,
  output logic          bus_io_rd,
  output logic          bus_mem_wr,
  output logic [AW-1:0] bus_io_addr,
  output logic [AW-1:0] bus_mem_addr,
  input  logic [DW-1:0] bus_rdata,
  output logic [DW-1:0] bus_wdata
);
  logic          rst_n_i;
  logic          armed, move_active, move_done, cnt_inc;
  logic [AW-1:0] src_addr, dst_addr;

  dma_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  dma_cfg_regs #(.AW(AW), .CW(CW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .cnt_inc   (cnt_inc),
    .cfg_rdata (cfg_rdata),
    .src_addr  (src_addr),
    .dst_addr  (dst_addr),
    .armed     (armed)
  );

  dma_seq_fsm u_seq (
    .clk         (clk),
    .rst_n       (rst_n_i),
    .armed       (armed),
    .per_req     (per_req),
    .hold_ack    (hold_ack),
    .move_done   (move_done),
    .hold_req    (hold_req),
    .per_ack     (per_ack),
    .move_active (move_active),
    .cnt_inc     (cnt_inc)
  );

  dma_bus_phase #(.AW(AW), .DW(DW), .PHASES(PHASES)) u_bus (
    .clk          (clk),
    .rst_n        (rst_n_i),
    .move_active  (move_active),
    .hold_ack     (hold_ack),
    .src_addr     (src_addr),
    .dst_addr     (dst_addr),
    .bus_rdata    (bus_rdata),
    .move_done    (move_done),
    .bus_oe       (bus_oe),
    .bus_ale      (bus_ale),
    .bus_io_rd    (bus_io_rd),
    .bus_mem_wr   (bus_mem_wr),
    .bus_io_addr  (bus_io_addr),
    .bus_mem_addr (bus_mem_addr),
    .bus_wdata    (bus_wdata)
  );
endmodule

// File: rtl/dma_p2m_checker.sv
module dma_p2m_checker #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          per_req,
  input logic          per_ack,
  input logic          hold_req,
  input logic          hold_ack,
  input logic          bus_oe,
  input logic          bus_ale,
  input logic          bus_io_rd,
  input logic          bus_mem_wr,
  input logic [DW-1:0] bus_wdata
);
  // R4: a bus request only follows a sampled peripheral request
  p_req_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_req) |-> $past(per_req));

  // R5: peripheral acknowledge only inside the bus request
  p_ack_in_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    per_ack |-> hold_req);

  // R6: drive only under the grant
  p_oe_grant_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> hold_ack);

  // R6: strobes need the output enable
  p_strobe_oe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_ale || bus_io_rd || bus_mem_wr) |-> bus_oe);

  // R7: address strobe lasts a single cycle
  p_ale_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ale |=> !bus_ale);

  // R8: written byte holds steady across the write strobe
  p_wdata_steady_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_mem_wr && $past(bus_mem_wr)) |-> $stable(bus_wdata));

  // R9: request and acknowledge fall together
  p_drop_together_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(per_ack) |-> !hold_req);

  // R10: no immediate re-request after a transaction
  p_no_rerequest_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_req) |=> !hold_req);
endmodule

bind dma_p2m_ctrl dma_p2m_checker #(.DW(DW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .per_req    (per_req),
  .per_ack    (per_ack),
  .hold_req   (hold_req),
  .hold_ack   (hold_ack),
  .bus_oe     (bus_oe),
  .bus_ale    (bus_ale),
  .bus_io_rd  (bus_io_rd),
  .bus_mem_wr (bus_mem_wr),
  .bus_wdata  (bus_wdata)
);

// File: tb/test_dma_p2m_ctrl.sv
`timescale 1ns/1ps
module test_dma_p2m_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [1:0]  cfg_sel;
  logic [15:0] cfg_wdata, cfg_rdata;
  logic        per_req, per_ack, hold_req, hold_ack;
  logic        bus_oe, bus_ale, bus_io_rd, bus_mem_wr;
  logic [15:0] bus_io_addr, bus_mem_addr;
  logic [7:0]  bus_rdata, bus_wdata;

  int n_cmp = 0;
  int n_bad = 0;
  int n_done = 0;

  always #5 clk = ~clk;

  dma_p2m_ctrl i_dma_p2m_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .per_req(per_req),
    .per_ack(per_ack), .hold_req(hold_req), .hold_ack(hold_ack),
    .bus_oe(bus_oe), .bus_ale(bus_ale), .bus_io_rd(bus_io_rd),
    .bus_mem_wr(bus_mem_wr), .bus_io_addr(bus_io_addr),
    .bus_mem_addr(bus_mem_addr), .bus_rdata(bus_rdata), .bus_wdata(bus_wdata)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference: mode 0 idle, 1 waiting grant, 2 moving, 3 draining
  int   m_mode, m_ph, m_src, m_dst, m_cnt, m_lat;
  bit   m_has_src, m_has_dst;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_ph = 0; m_src = 0; m_dst = 0; m_cnt = 0; m_lat = 0;
      m_has_src = 0; m_has_dst = 0;
    end else begin
      case (m_mode)
        0: if (m_has_src && m_has_dst && per_req) m_mode = 1;
        1: if (hold_ack) begin m_mode = 2; m_ph = 0; end
        2: begin
             if (hold_ack && m_ph == 2) m_lat = bus_rdata;
             if (m_ph == 6) begin m_mode = 3; m_ph = 0; m_cnt = (m_cnt + 1) % 256; end
             else m_ph++;
           end
        default: if (!per_req && !hold_ack) m_mode = 0;
      endcase
      if (cfg_we && cfg_sel == 2'd0) begin m_src = cfg_wdata; m_has_src = 1; end
      if (cfg_we && cfg_sel == 2'd1) begin m_dst = cfg_wdata; m_has_dst = 1; end
    end
  end

  // Compare all outputs against the reference on every falling edge
  always @(negedge clk) begin
    bit oe, wr;
    int rd;
    oe = (m_mode == 2) && hold_ack;
    wr = oe && m_ph >= 3 && m_ph <= 5;
    rd = (cfg_sel == 2'd0) ? m_src : (cfg_sel == 2'd1) ? m_dst :
         (cfg_sel == 2'd2) ? m_cnt : 0;
    chk("R4 hold_req", hold_req, (m_mode == 1 || m_mode == 2));
    chk("R5 per_ack", per_ack, (m_mode == 2));
    chk("R6 bus_oe", bus_oe, oe);
    chk("R7 bus_ale", bus_ale, oe && m_ph == 0);
    chk("R7 bus_io_rd", bus_io_rd, oe && m_ph >= 1 && m_ph <= 4);
    chk("R7 bus_mem_wr", bus_mem_wr, wr);
    chk("R8 bus_io_addr", bus_io_addr, oe ? m_src : 0);
    chk("R8 bus_mem_addr", bus_mem_addr, oe ? m_dst : 0);
    chk("R8 bus_wdata", bus_wdata, wr ? m_lat : 0);
    chk(cfg_sel == 2'd2 ? "R9 count" : "R2 readback", cfg_rdata, rd);
  end

  task automatic step(input int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #2;
    end
  endtask

  task automatic wr_reg(input logic [1:0] sel, input logic [15:0] val);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
    step();
    cfg_we = 1'b0; cfg_sel = 2'd2;
  endtask

  task automatic xfer(input logic [7:0] byte_v, input int grant_wait,
                      input int req_linger, input int ack_linger);
    bus_rdata = byte_v;
    per_req = 1'b1;
    while (!hold_req) step();
    step(grant_wait);
    hold_ack = 1'b1;
    while (!per_ack) step();
    while (per_ack) begin
      if (bus_mem_wr) chk("R8 byte moved", bus_wdata, byte_v);
      step();
    end
    for (int k = 0; k < req_linger; k++) begin
      chk("R10 no re-request, req held", hold_req, 0);
      step();
    end
    per_req = 1'b0;
    for (int k = 0; k < ack_linger; k++) begin
      chk("R10 no re-request, grant held", hold_req, 0);
      step();
    end
    hold_ack = 1'b0;
    step(2);
    n_done++;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = 2'd2; cfg_wdata = '0;
    per_req = 1'b0; hold_ack = 1'b0; bus_rdata = '0;
    step(3);
    // R1: reset state
    chk("R1 hold_req", hold_req, 0);
    chk("R1 per_ack", per_ack, 0);
    chk("R1 bus_oe", bus_oe, 0);
    for (int s = 0; s < 3; s++) begin
      cfg_sel = 2'(s); #1;
      chk("R1 register readback", cfg_rdata, 0);
    end
    cfg_sel = 2'd2;
    rst_n = 1'b1;
    step(4);

    // R3: request ignored before arming, and with only the source written
    per_req = 1'b1;
    for (int k = 0; k < 4; k++) begin step(); chk("R3 unarmed", hold_req, 0); end
    per_req = 1'b0;
    wr_reg(2'd0, 16'h1234);
    per_req = 1'b1;
    for (int k = 0; k < 4; k++) begin step(); chk("R3 half armed", hold_req, 0); end
    per_req = 1'b0;
    wr_reg(2'd1, 16'h0040);

    // R2: readback
    cfg_sel = 2'd0; step(); chk("R2 source readback", cfg_rdata, 16'h1234);
    cfg_sel = 2'd1; step(); chk("R2 dest readback", cfg_rdata, 16'h0040);
    cfg_sel = 2'd3; step(); chk("R2 unused select", cfg_rdata, 0);
    cfg_sel = 2'd2; step(); chk("R9 count start", cfg_rdata, 0);

    // Delayed grant, then a lingering request (R4, R5, R10)
    xfer(8'hA5, 3, 2, 1);
    chk("R9 count after one", cfg_rdata, 1);
    xfer(8'h3C, 0, 4, 0);

    // R6: grant withdrawn during the transaction
    per_req = 1'b1;
    while (!hold_req) step();
    hold_ack = 1'b1;
    while (!per_ack) step();
    step(2);
    hold_ack = 1'b0;
    step();
    chk("R6 oe off without grant", bus_oe, 0);
    chk("R6 write strobe off", bus_mem_wr, 0);
    step();
    chk("R6 read strobe off", bus_io_rd, 0);
    hold_ack = 1'b1;
    while (per_ack) step();
    per_req = 1'b0; hold_ack = 1'b0;
    step(2);
    n_done++;

    // New addresses, then many moves to wrap the counter (R9)
    wr_reg(2'd0, 16'h2000);
    wr_reg(2'd1, 16'h8001);
    xfer(8'h5A, 1, 1, 0);
    for (int i = 0; i < 253; i++) xfer(8'(i * 7 + 1), i % 3, i % 2, (i + 1) % 2);
    chk("R9 count wraps", cfg_rdata, 16'(n_done % 256));

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule